// File: doc/BRIEF.md
# Ethernet receive address filter

This block decides, for every incoming frame, whether the frame is kept or thrown away based on its destination address and length. The receive path presents the six destination bytes and the frame length once per frame on a valid/ready header port; one clock after the header is taken, a registered decision appears on a valid/ready decision port. The decision carries an accept flag, a runt flag for frames that passed every filter but are too short, and three flags that classify the destination as unicast, broadcast or multicast.

Filtering runs in two stages. The basic stage compares unicast destinations with the station address. It honours separate reject switches for broadcast and multicast. It matches multicast destinations against a small table of exact entries, and promiscuous mode skips this stage. The optional extended stage compares unicast destinations with a second station address and drops IPv4-mapped multicast. Other multicast destinations are looked up in a 32K-bit hash bitmap, held as 1024 words of 32 bits and written by software one word at a time. A sticky reject status bit records runt frames until software clears it.

Back-pressure: a header is taken on a clock edge where `hdr_valid` and `hdr_ready` are both high. `hdr_ready` is high whenever no decision is pending or the pending one is being taken in the same cycle. A decision stays on the outputs, unchanged, until `dec_ready` is high.

Top module: `rxf_dest_filter`

## Requirements
- R1: Destination bytes are numbered 0 to 5, with byte 0 on `hdr_dest[7:0]` and byte k on `hdr_dest[8k+7:8k]`. A destination is unicast when bit 0 of byte 0 is 0. It is broadcast when all six bytes are 0xFF, and multicast otherwise. Exactly one of the three decision flags is set with every decision.
- R2: Without promiscuous mode, a unicast frame passes the basic stage only when byte 0 to byte 3 equal `cfg_ucast_lo` bits 7:0, 15:8, 23:16 and 31:24, and byte 4 and byte 5 equal `cfg_ucast_hi` bits 7:0 and 15:8.
- R3: Without promiscuous mode, broadcast frames are dropped when `cfg_bcast_rej` is 1. Multicast frames are dropped when `cfg_mcast_rej` is 1, whatever the table holds.
- R4: The multicast table has four entries, each with a low word and a high word laid out as in R2. `mc_sel` picks the entry that is written (`mc_wr_half` 0 = low word, 1 = high word) and the entry that is read back on `mc_rd_data` (`mc_rd_half` picks the word). Without promiscuous mode and with `cfg_mcast_rej` at 0, a multicast frame passes the basic stage only if it equals one entry. All entries reset to zero.
- R5: With `cfg_promisc` at 1, the basic stage passes every frame.
- R6: The extended stage is active only when `cfg_ext_gate` and `cfg_ext_mcast` are both 1. When it is active, unicast frames must also equal the second address (`cfg_xucast_lo`/`cfg_xucast_hi`, same layout as R2), and broadcast frames are dropped when `cfg_bcast_rej` is 1.
- R7: In the extended stage, the hash index of a multicast frame is {byte4[6:0], byte5}. The bitmap word is index[14:5], the bit within that word is index[4:0], and the frame is dropped when that bit is 0. A bitmap word written with `bm_wr_en` is used by headers taken from the next cycle on.
- R8: In the extended stage, a multicast frame whose bytes 0, 1 and 2 are 0x01, 0x00 and 0x5E is dropped before the bitmap is consulted.
- R9: When `cfg_jumbo` and `cfg_vlan` are both 0, frames of length 1519 to 1522 are dropped. Frames of length 1518 or 1523 are not dropped by this rule, and neither is any length when either bit is 1.
- R10: A frame shorter than 12 bytes that passes every filter gives `dec_runt` = 1 and `dec_accept` = 0. A frame that some filter drops gives neither flag. Any other frame that passes every filter is accepted.
- R11: `rej_status` is set by each decision with `dec_runt` = 1, on the edge that registers that decision. It is cleared by `rej_clr`. When a set and a clear fall in the same cycle, the set wins. It resets to 0.
- R12: A header taken on an edge produces its decision on that same edge, so the decision is visible in the following cycle. While `dec_ready` is 0, the decision and `dec_valid` hold and `hdr_ready` is 0. After reset `dec_valid` is 0 and `hdr_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hdr_valid | input | 1 | Header offered |
| hdr_ready | output | 1 | Header can be taken this cycle |
| hdr_dest | input | 48 | Destination bytes, byte 0 in bits 7:0 |
| hdr_len | input | 16 | Frame length in bytes |
| dec_valid | output | 1 | Decision present |
| dec_ready | input | 1 | Consumer takes the decision |
| dec_accept | output | 1 | Frame is kept |
| dec_runt | output | 1 | Frame passed the filters but is too short |
| dec_ucast | output | 1 | Destination is unicast |
| dec_bcast | output | 1 | Destination is broadcast |
| dec_mcast | output | 1 | Destination is multicast |
| cfg_promisc | input | 1 | Skip the basic stage |
| cfg_bcast_rej | input | 1 | Drop broadcast frames |
| cfg_mcast_rej | input | 1 | Drop multicast frames in the basic stage |
| cfg_ext_gate | input | 1 | Extended stage enable, first of two |
| cfg_ext_mcast | input | 1 | Extended stage enable, second of two |
| cfg_jumbo | input | 1 | Long frames allowed |
| cfg_vlan | input | 1 | Tagged-length frames allowed |
| cfg_ucast_lo | input | 32 | Station address bytes 0 to 3 |
| cfg_ucast_hi | input | 16 | Station address bytes 4 and 5 |
| cfg_xucast_lo | input | 32 | Second address bytes 0 to 3 |
| cfg_xucast_hi | input | 16 | Second address bytes 4 and 5 |
| mc_sel | input | 2 | Multicast entry selected for write and read |
| mc_wr_en | input | 1 | Write the selected entry word |
| mc_wr_half | input | 1 | Word written: 0 low, 1 high |
| mc_wr_data | input | 32 | Entry write data |
| mc_rd_half | input | 1 | Word read: 0 low, 1 high |
| mc_rd_data | output | 32 | Selected entry word |
| bm_wr_en | input | 1 | Write one bitmap word |
| bm_wr_addr | input | 10 | Bitmap word address |
| bm_wr_data | input | 32 | Bitmap word data |
| rej_clr | input | 1 | Clear the reject status |
| rej_status | output | 1 | Sticky runt-frame status |

## Verification
Two functions can fall in the same cycle. A runt decision can be registered while software clears the reject status, and a header can arrive while the consumer is stalling the previous decision. The bench holds `rej_clr` high through the cycle in which a short, address-matching header is taken. The status must read 1 afterwards and 0 after a lone clear. In the stall case it drops `dec_ready` with two headers queued, and the first decision must hold unchanged while `hdr_ready` stays low. A behavioural model of the ordering rules judges both cases every clock.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int DA_W = 48;

  typedef enum logic [1:0] {
    DA_UCAST = 2'd0,
    DA_BCAST = 2'd1,
    DA_MCAST = 2'd2
  } da_kind_e;

  typedef struct packed {
    logic     accept;
    logic     runt;
    da_kind_e kind;
  } decision_t;
endpackage

// File: rtl/rxf_classify.sv
module rxf_classify
  import rxf_pkg::*;
(
  input  logic [DA_W-1:0] dest,
  output da_kind_e        kind,
  output logic            ip_prefix
);
  always_comb begin
    if (!dest[0])     kind = DA_UCAST;
    else if (&dest)   kind = DA_BCAST;
    else              kind = DA_MCAST;
    // bytes 0..2 = 01 00 5E
    ip_prefix = (dest[23:0] == 24'h5E0001);
  end
endmodule

// File: rtl/rxf_mcast_table.sv
module rxf_mcast_table
  import rxf_pkg::*;
#(
  parameter int ENTRIES = 4,
  localparam int SEL_W = $clog2(ENTRIES)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic             wr_en,
  input  logic             wr_half,
  input  logic [31:0]      wr_data,
  input  logic             rd_half,
  output logic [31:0]      rd_data,
  input  logic [DA_W-1:0]  dest,
  output logic             hit
);
  logic [31:0]        lo_q [ENTRIES];
  logic [31:0]        hi_q [ENTRIES];
  logic [ENTRIES-1:0] hit_vec;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q[i] <= '0;
        hi_q[i] <= '0;
      end else if (wr_en && sel == SEL_W'(i)) begin
        if (wr_half) hi_q[i] <= wr_data;
        else         lo_q[i] <= wr_data;
      end
    end
    assign hit_vec[i] = (dest == {hi_q[i][15:0], lo_q[i]});
  end

  assign hit     = |hit_vec;
  assign rd_data = rd_half ? hi_q[sel] : lo_q[sel];
endmodule

// File: rtl/rxf_hash_map.sv
module rxf_hash_map #(
  parameter int WORDS = 1024,
  parameter int BITS  = 32,
  localparam int AW  = $clog2(WORDS),
  localparam int BW  = $clog2(BITS)
)(
  input  logic            clk,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [BITS-1:0] wr_data,
  input  logic [AW-1:0]   lk_word,
  input  logic [BW-1:0]   lk_bit,
  output logic            lk_hit
);
  logic [BITS-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign lk_hit = mem[lk_word][lk_bit];
endmodule

// File: rtl/rxf_dest_filter.sv
module rxf_dest_filter
  import rxf_pkg::*;
#(
  parameter int LEN_W      = 16,
  parameter int MC_ENTRIES = 4,
  parameter int BM_WORDS   = 1024,
  parameter int BM_BITS    = 32,
  parameter int MIN_LEN    = 12,
  parameter int STD_MAX    = 1518,
  parameter int TAG_MAX    = 1522,
  localparam int SEL_W  = $clog2(MC_ENTRIES),
  localparam int BM_AW  = $clog2(BM_WORDS),
  localparam int BIT_AW = $clog2(BM_BITS),
  localparam int HASH_W = BM_AW + BIT_AW,
  localparam int HI_W   = HASH_W - 8
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hdr_valid,
  output logic               hdr_ready,
  input  logic [DA_W-1:0]    hdr_dest,
  input  logic [LEN_W-1:0]   hdr_len,
  output logic               dec_valid,
  input  logic               dec_ready,
  output logic               dec_accept,
  output logic               dec_runt,
  output logic               dec_ucast,
  output logic               dec_bcast,
  output logic               dec_mcast,
  input  logic               cfg_promisc,
  input  logic               cfg_bcast_rej,
  input  logic               cfg_mcast_rej,
  input  logic               cfg_ext_gate,
  input  logic               cfg_ext_mcast,
  input  logic               cfg_jumbo,
  input  logic               cfg_vlan,
  input  logic [31:0]        cfg_ucast_lo,
  input  logic [15:0]        cfg_ucast_hi,
  input  logic [31:0]        cfg_xucast_lo,
  input  logic [15:0]        cfg_xucast_hi,
  input  logic [SEL_W-1:0]   mc_sel,
  input  logic               mc_wr_en,
  input  logic               mc_wr_half,
  input  logic [31:0]        mc_wr_data,
  input  logic               mc_rd_half,
  output logic [31:0]        mc_rd_data,
  input  logic               bm_wr_en,
  input  logic [BM_AW-1:0]   bm_wr_addr,
  input  logic [BM_BITS-1:0] bm_wr_data,
  input  logic               rej_clr,
  output logic               rej_status
);
  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] STD_L = LEN_W'(STD_MAX);
  localparam logic [LEN_W-1:0] TAG_L = LEN_W'(TAG_MAX);

  da_kind_e          kind;
  logic              ip_pfx;
  logic              mc_hit;
  logic              bm_hit;
  logic [HASH_W-1:0] hidx;
  logic              tag_drop, basic_drop, ext_drop, passed, too_short;
  logic              fire;
  decision_t         dec_q;

  rxf_classify u_cls (
    .dest      (hdr_dest),
    .kind      (kind),
    .ip_prefix (ip_pfx)
  );

  rxf_mcast_table #(.ENTRIES(MC_ENTRIES)) u_mct (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (mc_sel),
    .wr_en   (mc_wr_en),
    .wr_half (mc_wr_half),
    .wr_data (mc_wr_data),
    .rd_half (mc_rd_half),
    .rd_data (mc_rd_data),
    .dest    (hdr_dest),
    .hit     (mc_hit)
  );

  // index = {byte4 low bits, byte5}
  assign hidx = {hdr_dest[32 +: HI_W], hdr_dest[40 +: 8]};

  rxf_hash_map #(.WORDS(BM_WORDS), .BITS(BM_BITS)) u_bm (
    .clk     (clk),
    .wr_en   (bm_wr_en),
    .wr_addr (bm_wr_addr),
    .wr_data (bm_wr_data),
    .lk_word (hidx[HASH_W-1:BIT_AW]),
    .lk_bit  (hidx[BIT_AW-1:0]),
    .lk_hit  (bm_hit)
  );

  always_comb begin
    tag_drop = !cfg_jumbo && !cfg_vlan && (hdr_len > STD_L) && (hdr_len <= TAG_L);

    basic_drop = 1'b0;
    if (!cfg_promisc) begin
      unique case (kind)
        DA_UCAST: basic_drop = (hdr_dest != {cfg_ucast_hi, cfg_ucast_lo});
        DA_BCAST: basic_drop = cfg_bcast_rej;
        default:  basic_drop = cfg_mcast_rej || !mc_hit;
      endcase
    end

    ext_drop = 1'b0;
    if (cfg_ext_gate && cfg_ext_mcast) begin
      unique case (kind)
        DA_UCAST: ext_drop = (hdr_dest != {cfg_xucast_hi, cfg_xucast_lo});
        DA_BCAST: ext_drop = cfg_bcast_rej;
        default:  ext_drop = ip_pfx || !bm_hit;
      endcase
    end

    passed    = !(tag_drop || basic_drop || ext_drop);
    too_short = hdr_len < MIN_L;
  end

  assign hdr_ready = !dec_valid || dec_ready;
  assign fire      = hdr_valid && hdr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      dec_q     <= '{accept: 1'b0, runt: 1'b0, kind: DA_UCAST};
    end else if (fire) begin
      dec_valid    <= 1'b1;
      dec_q.accept <= passed && !too_short;
      dec_q.runt   <= passed && too_short;
      dec_q.kind   <= kind;
    end else if (dec_ready) begin
      dec_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          rej_status <= 1'b0;
    else if (fire && passed && too_short) rej_status <= 1'b1;
    else if (rej_clr)                    rej_status <= 1'b0;
  end

  assign dec_accept = dec_q.accept;
  assign dec_runt   = dec_q.runt;
  assign dec_ucast  = (dec_q.kind == DA_UCAST);
  assign dec_bcast  = (dec_q.kind == DA_BCAST);
  assign dec_mcast  = (dec_q.kind == DA_MCAST);
endmodule

// File: rtl/rxf_dest_filter_chk.sv
module rxf_dest_filter_chk #(
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 12
)(
  input logic             clk,
  input logic             rst_n,
  input logic             hdr_valid,
  input logic             hdr_ready,
  input logic [LEN_W-1:0] hdr_len,
  input logic             dec_valid,
  input logic             dec_ready,
  input logic             dec_accept,
  input logic             dec_runt,
  input logic             dec_ucast,
  input logic             dec_bcast,
  input logic             dec_mcast,
  input logic             rej_status
);
  logic             took_q;
  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      took_q <= 1'b0;
      len_q  <= '0;
    end else begin
      took_q <= hdr_valid && hdr_ready;
      if (hdr_valid && hdr_ready) len_q <= hdr_len;
    end
  end

  AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $countones({dec_ucast, dec_bcast, dec_mcast}) == 1); // R1
  AST_NO_ACCEPT_RUNT: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> !(dec_accept && dec_runt)); // R10
  AST_RUNT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (took_q && dec_runt) |-> (len_q < LEN_W'(MIN_LEN))); // R10
  AST_RUNT_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (took_q && dec_runt) |-> rej_status); // R11
  AST_TAKE_GIVES_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && hdr_ready) |=> dec_valid); // R12
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_ready) |=> dec_valid &&
      $stable({dec_accept, dec_runt, dec_ucast, dec_bcast, dec_mcast})); // R12
endmodule

bind rxf_dest_filter rxf_dest_filter_chk #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_chk (.*);

// File: tb/rxf_dest_filter_tb.sv
module rxf_dest_filter_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        hdr_valid, hdr_ready;
  logic [47:0] hdr_dest;
  logic [15:0] hdr_len;
  logic        dec_valid, dec_ready, dec_accept, dec_runt, dec_ucast, dec_bcast, dec_mcast;
  logic        cfg_promisc, cfg_bcast_rej, cfg_mcast_rej, cfg_ext_gate, cfg_ext_mcast;
  logic        cfg_jumbo, cfg_vlan;
  logic [31:0] cfg_ucast_lo, cfg_xucast_lo;
  logic [15:0] cfg_ucast_hi, cfg_xucast_hi;
  logic [1:0]  mc_sel;
  logic        mc_wr_en, mc_wr_half, mc_rd_half;
  logic [31:0] mc_wr_data, mc_rd_data;
  logic        bm_wr_en;
  logic [9:0]  bm_wr_addr;
  logic [31:0] bm_wr_data;
  logic        rej_clr, rej_status;

  always #5 clk = ~clk;

  rxf_dest_filter u_dut (.*);

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R12";

  // behavioural reference state
  bit          e_valid, e_acc, e_runt, e_u, e_b, e_m, e_stat;
  logic [31:0] m_lo [4];
  logic [31:0] m_hi [4];
  logic [31:0] m_bm [1024];

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  function automatic bit addr_eq(input logic [7:0] by [6], input logic [31:0] lo, input logic [15:0] hi);
    bit ok = 1;
    for (int i = 0; i < 4; i++) if (by[i] != lo[8*i +: 8]) ok = 0;
    if (by[4] != hi[7:0] || by[5] != hi[15:8]) ok = 0;
    return ok;
  endfunction

  task automatic ref_decide(input logic [47:0] d, input int len,
                            output bit acc, output bit rnt, output bit u, output bit b, output bit m);
    logic [7:0] by [6];
    bit drop = 0;
    bit hit = 0;
    int idx;
    for (int i = 0; i < 6; i++) by[i] = d[8*i +: 8];
    u = (by[0][0] == 1'b0);
    b = 1;
    for (int i = 0; i < 6; i++) if (by[i] != 8'hFF) b = 0;
    m = !u && !b;
    if (!cfg_jumbo && !cfg_vlan && len >= 1519 && len <= 1522) drop = 1;
    if (!cfg_promisc) begin
      if (u) begin
        if (!addr_eq(by, cfg_ucast_lo, cfg_ucast_hi)) drop = 1;
      end else if (b) begin
        if (cfg_bcast_rej) drop = 1;
      end else if (cfg_mcast_rej) begin
        drop = 1;
      end else begin
        for (int i = 0; i < 4; i++) if (addr_eq(by, m_lo[i], m_hi[i][15:0])) hit = 1;
        if (!hit) drop = 1;
      end
    end
    if (cfg_ext_gate && cfg_ext_mcast) begin
      if (u) begin
        if (!addr_eq(by, cfg_xucast_lo, cfg_xucast_hi)) drop = 1;
      end else if (b) begin
        if (cfg_bcast_rej) drop = 1;
      end else if (by[0] == 8'h01 && by[1] == 8'h00 && by[2] == 8'h5E) begin
        drop = 1;
      end else begin
        idx = int'(by[4] & 8'h7F) * 256 + int'(by[5]);
        if (m_bm[idx / 32][idx % 32] == 1'b0) drop = 1;
      end
    end
    rnt = !drop && len < 12;
    acc = !drop && len >= 12;
  endtask

  always @(negedge clk) begin
    bit fire, a, r, u, b, m;
    chk("hdr_ready", {31'd0, hdr_ready}, {31'd0, (!e_valid || dec_ready)});
    chk("dec_valid", {31'd0, dec_valid}, {31'd0, e_valid});
    if (e_valid) begin
      chk("dec_accept", {31'd0, dec_accept}, {31'd0, e_acc});
      chk("dec_runt",   {31'd0, dec_runt},   {31'd0, e_runt});
      chk("flags u/b/m", {29'd0, dec_ucast, dec_bcast, dec_mcast}, {29'd0, e_u, e_b, e_m});
    end
    chk("rej_status", {31'd0, rej_status}, {31'd0, e_stat});
    chk("mc_rd_data", mc_rd_data, mc_rd_half ? m_hi[mc_sel] : m_lo[mc_sel]);
    if (!rst_n) begin
      e_valid = 0; e_stat = 0;
      for (int i = 0; i < 4; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
    end else begin
      fire = hdr_valid && (!e_valid || dec_ready);
      r = 0;
      if (fire) begin
        ref_decide(hdr_dest, int'(hdr_len), a, r, u, b, m);
        e_valid = 1; e_acc = a; e_runt = r; e_u = u; e_b = b; e_m = m;
      end else if (dec_ready) begin
        e_valid = 0;
      end
      if (fire && r) e_stat = 1;
      else if (rej_clr) e_stat = 0;
      if (mc_wr_en) begin
        if (mc_wr_half) m_hi[mc_sel] = mc_wr_data;
        else            m_lo[mc_sel] = mc_wr_data;
      end
      if (bm_wr_en) m_bm[bm_wr_addr] = bm_wr_data;
    end
  end

  function automatic logic [47:0] mk(input logic [7:0] b0, b1, b2, b3, b4, b5);
    return {b5, b4, b3, b2, b1, b0};
  endfunction

  task automatic send(input logic [47:0] d, input int len);
    hdr_dest  = d;
    hdr_len   = len[15:0];
    hdr_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (hdr_ready) break;
    end
    @(posedge clk); #1;
    hdr_valid = 1'b0;
  endtask

  task automatic mc_write(input logic [1:0] s, input logic h, input logic [31:0] d);
    mc_sel = s; mc_wr_half = h; mc_wr_data = d; mc_wr_en = 1'b1;
    @(posedge clk); #1;
    mc_wr_en = 1'b0;
  endtask

  task automatic bm_write(input int a, input logic [31:0] d);
    bm_wr_addr = a[9:0]; bm_wr_data = d; bm_wr_en = 1'b1;
    @(posedge clk); #1;
    bm_wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R12 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  localparam logic [47:0] UC  = 48'h554433221102;
  localparam logic [47:0] XUC = 48'h0A0B0C0D0E10;
  localparam logic [47:0] BC  = 48'hFFFFFFFFFFFF;

  initial begin
    rst_n = 0; hdr_valid = 0; hdr_dest = '0; hdr_len = '0; dec_ready = 1;
    cfg_promisc = 0; cfg_bcast_rej = 0; cfg_mcast_rej = 0; cfg_ext_gate = 0; cfg_ext_mcast = 0;
    cfg_jumbo = 0; cfg_vlan = 0;
    cfg_ucast_lo = 32'h33221102; cfg_ucast_hi = 16'h5544;
    cfg_xucast_lo = 32'h0D0E10 | 32'h0C000000; cfg_xucast_hi = 16'h0A0B;
    mc_sel = 0; mc_wr_en = 0; mc_wr_half = 0; mc_wr_data = '0; mc_rd_half = 0;
    bm_wr_en = 0; bm_wr_addr = '0; bm_wr_data = '0; rej_clr = 0;
    cur_req = "R12";
    idle(3);
    rst_n = 1;
    idle(1);

    // clear the bitmap, one word per cycle
    bm_wr_en = 1'b1; bm_wr_data = '0;
    for (int i = 0; i < 1024; i++) begin
      bm_wr_addr = i[9:0];
      @(posedge clk); #1;
    end
    bm_wr_en = 1'b0;

    cur_req = "R2";
    send(UC, 64);
    send(mk(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h56), 64);
    send(mk(8'h55, 8'h44, 8'h33, 8'h22, 8'h11, 8'h02) & ~48'h1, 64);

    cur_req = "R1";
    send(BC, 64);
    send(mk(8'h33, 8'h33, 8'h00, 8'h00, 8'h00, 8'h09), 64);
    send(mk(8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFE), 64);

    cur_req = "R4";
    mc_write(2, 0, 32'h00003333);
    mc_write(2, 1, 32'hABCD0100);
    mc_rd_half = 1; idle(1);
    mc_rd_half = 0; idle(1);
    send(mk(8'h33, 8'h33, 8'h00, 8'h00, 8'h00, 8'h01), 64);
    send(mk(8'h33, 8'h33, 8'h00, 8'h00, 8'h00, 8'h02), 64);
    mc_write(3, 0, 32'h00003333);
    mc_write(3, 1, 32'h00000200);
    mc_sel = 1; idle(1);
    send(mk(8'h33, 8'h33, 8'h00, 8'h00, 8'h00, 8'h02), 64);

    cur_req = "R3";
    cfg_bcast_rej = 1; idle(1);
    send(BC, 64);
    cfg_bcast_rej = 0; cfg_mcast_rej = 1; idle(1);
    send(mk(8'h33, 8'h33, 8'h00, 8'h00, 8'h00, 8'h01), 64);
    cfg_mcast_rej = 0; idle(1);

    cur_req = "R5";
    cfg_promisc = 1; cfg_bcast_rej = 1; idle(1);
    send(mk(8'h02, 8'h99, 8'h99, 8'h99, 8'h99, 8'h99), 64);
    send(mk(8'h33, 8'h33, 8'h77, 8'h00, 8'h00, 8'h05), 64);
    send(BC, 64);
    cfg_bcast_rej = 0; idle(1);

    cur_req = "R6";
    cfg_ext_gate = 1; idle(1);
    send(UC, 64);
    cfg_ext_mcast = 1; idle(1);
    send(UC, 64);
    send(XUC, 64);
    cfg_bcast_rej = 1; idle(1);
    send(BC, 64);
    cfg_bcast_rej = 0; idle(1);

    cur_req = "R7";
    send(mk(8'h33, 8'h33, 8'h00, 8'h00, 8'h83, 8'h45), 64);
    bm_write(26, 32'h00000020);
    send(mk(8'h33, 8'h33, 8'h00, 8'h00, 8'h83, 8'h45), 64);
    send(mk(8'h33, 8'h33, 8'h00, 8'h00, 8'h03, 8'h45), 64);
    send(mk(8'h33, 8'h33, 8'h00, 8'h00, 8'h03, 8'h46), 64);

    cur_req = "R8";
    send(mk(8'h01, 8'h00, 8'h5E, 8'h00, 8'h83, 8'h45), 64);
    send(mk(8'h01, 8'h00, 8'h5F, 8'h00, 8'h83, 8'h45), 64);
    cfg_ext_gate = 0; cfg_ext_mcast = 0; idle(1);

    cur_req = "R9";
    send(UC, 1518);
    send(UC, 1519);
    send(UC, 1522);
    send(UC, 1523);
    cfg_vlan = 1; idle(1);
    send(UC, 1520);
    cfg_vlan = 0; cfg_jumbo = 1; idle(1);
    send(UC, 1521);
    cfg_jumbo = 0; idle(1);

    cur_req = "R10";
    cfg_promisc = 0; idle(1);
    send(UC, 11);
    send(UC, 12);
    send(mk(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h57), 5);

    cur_req = "R11";
    rej_clr = 1; idle(1);
    rej_clr = 0; idle(1);
    rej_clr = 1;
    send(UC, 8);
    rej_clr = 0; idle(1);
    rej_clr = 1; idle(1);
    rej_clr = 0; idle(1);

    cur_req = "R12";
    dec_ready = 0;
    send(UC, 64);
    hdr_dest = BC; hdr_len = 16'd64; hdr_valid = 1;
    idle(4);
    dec_ready = 1;
    forever begin
      @(negedge clk);
      if (hdr_ready) break;
    end
    @(posedge clk); #1;
    hdr_valid = 0;
    idle(3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule